// File: doc/BRIEF.md
# Oversampling Serial Receiver With Address Filter

This block receives asynchronous serial characters. It watches a serial line with a one-cycle tick that runs at sixteen times the bit rate. A falling line starts a frame, but only if the line is still low half a bit later. After that, each bit is taken as the majority of three samples placed around the middle of the bit cell. A finished character passes from the shift register into a read buffer. The buffer-full flag is set at that point and stays set until the reader pulses the read strobe. The bit-rate tick comes from outside the block.

Characters carry 7, 8 or 9 data bits, least significant bit first. In the 7-bit and 8-bit formats an optional parity bit follows the data and is checked against one of four rules. The receiver requires a single stop bit. A low stop sample flags a framing error. A frame that is low from start to stop also flags a break. After a low stop bit the block waits for the line to return high before it looks for a new start.

For multidrop links there is an address-filter bit. While it is set in a 9-bit format, characters whose ninth bit is 0 are dropped. The first character whose ninth bit is 1 is stored, and the filter bit then clears itself. A diagnostic loopback format takes the serial stream from the local transmitter output instead of the pin. A receive interrupt request follows the buffer-full flag, gated by an enable.

Top module: `uart_rx_top`

## Requirements
- R1: After synchronous reset, rx_full, par_err, frm_err, brk_det, line_fault, attn, irq, rd_bit9 and rd_data are all zero.
- R2: A start is accepted only if the line is still low at the 8th tick after the tick that saw it fall. A shorter low pulse produces no character.
- R3: Each data, parity and stop bit is the majority of the samples taken at ticks 7, 8 and 9 of its cell. A one-tick glitch inside a bit does not change the received value.
- R4: fmt_sel selects the format: 00 gives 8 data bits, 01 gives 7, 10 gives 9, and 11 gives 9 in loopback. Data arrives LSB first. rd_data holds the low 8 data bits with unused upper bits zero, and rd_bit9 holds the ninth bit in the 9-bit formats (0 otherwise).
- R5: rx_full rises one clock after the tick that samples the middle of the stop bit. It is low 8 ticks into the stop bit and high 12 ticks into it.
- R6: A one-cycle rd_strobe clears rx_full on the next clock and leaves rd_data unchanged. A store in the same cycle takes priority.
- R7: One stop bit is enough. A frame whose start bit directly follows the previous stop bit is received.
- R8: In the 7-bit and 8-bit formats, par_en=1 adds a parity bit after the data. par_mode 00 requires odd total parity, 01 even, 10 a constant 1 and 11 a constant 0. par_err reports a mismatch for the stored character.
- R9: frm_err is set for a stored character whose stop bit reads 0. brk_det is also set if all data and parity bits read 0 as well. Both are replaced at the next store.
- R10: line_fault rises when a stop bit reads 0 and falls once the line is high. No new start is detected while the line stays low after such a frame.
- R11: attn_set sets attn and attn_clr clears it. While attn=1 in a 9-bit format, characters with ninth bit 0 are discarded. The first one with ninth bit 1 is stored and clears attn. In the 7-bit and 8-bit formats attn has no effect.
- R12: irq is high exactly while rx_full and rx_ie are both 1.
- R13: With fmt_sel=11 the receiver takes its input from lb_tx_in and ignores rx_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_in | input | 1 | Serial line from the pin (asynchronous) |
| lb_tx_in | input | 1 | Local transmitter output used in loopback |
| fmt_sel | input | 2 | Frame format select |
| par_en | input | 1 | Parity bit present (7/8-bit formats) |
| par_mode | input | 2 | Parity rule |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Read pulse, clears rx_full |
| attn_set | input | 1 | Pulse that sets the address filter |
| attn_clr | input | 1 | Pulse that clears the address filter |
| rd_data | output | 8 | Received character, low 8 bits |
| rd_bit9 | output | 1 | Received ninth bit |
| rx_full | output | 1 | Read buffer holds an unread character |
| par_err | output | 1 | Parity mismatch on stored character |
| frm_err | output | 1 | Stop bit read 0 on stored character |
| brk_det | output | 1 | Stored character was an all-low break |
| line_fault | output | 1 | Low stop seen, line not yet back high |
| attn | output | 1 | Address filter active |
| irq | output | 1 | Receive interrupt request |

## Verification
The stored character and its flags appear one clock after the mid-stop tick. That tick falls 9 to 11 ticks into the stop bit, counting the two-stage synchronizer and the detection-tick uncertainty. The bench therefore samples rx_full at 8 and at 12 ticks into the stop bit, and checks data and flags only after the 12-tick point. Read clearing, interrupt gating and the filter bit update are checked at the falling edge that follows the driving edge, one register later. line_fault is checked one tick after the line is released, which covers the synchronizer and its register.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  // Frame formats as encoded on fmt_sel
  typedef enum logic [1:0] {
    FMT_8    = 2'b00,
    FMT_7    = 2'b01,
    FMT_9    = 2'b10,
    FMT_LOOP = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    PAR_ODD  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ONE  = 2'b10,
    PAR_ZERO = 2'b11
  } par_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BITS, S_STOP, S_HOLD
  } rx_state_e;

  // Longest payload: nine data bits, or eight plus parity
  localparam int RX_MAXB = 10;

  typedef struct packed {
    logic [8:0] data;
    logic       par_err;
    logic       frm_err;
    logic       brk;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_front.sv
module uart_rx_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  input  logic lb_in,
  input  logic loop_en,
  output logic line
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[STAGES-2:0], rx_in};
  end

  // loopback source is already in this clock domain
  assign line = loop_en ? lb_in : sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line,
  input  logic restart,
  output logic half_stb,
  output logic half_val,
  output logic vote_stb,
  output logic vote
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  logic [CW-1:0] phase_q;
  logic [CW-1:0] num;
  logic [1:0]    early_q;

  // tick number within the current bit cell; detection tick is number 0
  always_comb num = restart ? '0 : phase_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      early_q <= '1;
    end else if (tick) begin
      phase_q <= num;
      if (num == CW'(MID - 1) || num == CW'(MID))
        early_q <= {early_q[0], line};
    end
  end

  assign half_stb = tick && (num == CW'(MID));
  assign half_val = line;
  assign vote_stb = tick && (num == CW'(MID + 1));
  assign vote     = (early_q[1] & early_q[0]) | (early_q[1] & line) | (early_q[0] & line);
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     line,
  input  logic     half_stb,
  input  logic     half_val,
  input  logic     vote_stb,
  input  logic     vote,
  input  fmt_e     fmt,
  input  logic     par_en,
  input  par_e     par_mode,
  output logic     restart,
  output logic     done,
  output logic     nine,
  output rx_char_t ch,
  output logic     line_fault
);
  localparam int IW = $clog2(RX_MAXB);

  rx_state_e          st;
  fmt_e               fmt_q;
  logic               pen_q;
  par_e               pm_q;
  logic [RX_MAXB-1:0] sh_q;
  logic [IW-1:0]      idx_q;

  logic [IW-1:0] ndata;
  logic [IW-1:0] last;
  logic [8:0]    dmask;
  logic [8:0]    dbits;
  logic          use_par;
  logic          pbit;
  logic          par_bad;

  assign restart = (st == S_IDLE) && tick && !line;
  assign nine    = fmt_q[1];
  assign use_par = pen_q && !fmt_q[1];

  always_comb begin
    unique case (fmt_q)
      FMT_7:   begin ndata = IW'(7); dmask = 9'h07F; end
      FMT_8:   begin ndata = IW'(8); dmask = 9'h0FF; end
      default: begin ndata = IW'(9); dmask = 9'h1FF; end
    endcase
    last  = ndata - 1'b1 + IW'(use_par);
    dbits = sh_q[8:0] & dmask;
    pbit  = sh_q[ndata];
    unique case (pm_q)
      PAR_ODD:  par_bad = ~(^dbits ^ pbit);
      PAR_EVEN: par_bad = ^dbits ^ pbit;
      PAR_ONE:  par_bad = ~pbit;
      default:  par_bad = pbit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      fmt_q      <= FMT_8;
      pen_q      <= 1'b0;
      pm_q       <= PAR_ODD;
      sh_q       <= '0;
      idx_q      <= '0;
      done       <= 1'b0;
      ch         <= '0;
      line_fault <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_STOP && vote_stb && !vote) line_fault <= 1'b1;
      else if (line)                          line_fault <= 1'b0;

      unique case (st)
        S_IDLE: begin
          if (restart) begin
            st    <= S_START;
            fmt_q <= fmt;
            pen_q <= par_en;
            pm_q  <= par_mode;
            sh_q  <= '0;
            idx_q <= '0;
          end
        end
        S_START: begin
          if (half_stb && half_val) st <= S_IDLE;
          else if (vote_stb)        st <= S_BITS;
        end
        S_BITS: begin
          if (vote_stb) begin
            sh_q[idx_q] <= vote;
            if (idx_q == last) st <= S_STOP;
            else               idx_q <= idx_q + 1'b1;
          end
        end
        S_STOP: begin
          if (vote_stb) begin
            done       <= 1'b1;
            ch.data    <= dbits;
            ch.par_err <= use_par && par_bad;
            ch.frm_err <= !vote;
            ch.brk     <= !vote && (sh_q == '0);
            st         <= vote ? S_IDLE : S_HOLD;
          end
        end
        S_HOLD:  if (line) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       done,
  input  logic       nine,
  input  rx_char_t   ch,
  input  logic       rd_strobe,
  input  logic       attn_set,
  input  logic       attn_clr,
  output logic       store,
  output logic [7:0] rd_data,
  output logic       rd_bit9,
  output logic       full,
  output logic       par_err,
  output logic       frm_err,
  output logic       brk,
  output logic       attn
);
  // filter drops 9-bit characters with a clear ninth bit while attn is set
  assign store = done && !(attn && nine && !ch.data[8]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_bit9 <= 1'b0;
      full    <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      brk     <= 1'b0;
      attn    <= 1'b0;
    end else begin
      if (store) begin
        rd_data <= ch.data[7:0];
        rd_bit9 <= ch.data[8];
        par_err <= ch.par_err;
        frm_err <= ch.frm_err;
        brk     <= ch.brk;
        full    <= 1'b1;
      end else if (rd_strobe) begin
        full <= 1'b0;
      end
      if (attn_set)                      attn <= 1'b1;
      else if (attn_clr || (store && nine)) attn <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx_in,
  input  logic       lb_tx_in,
  input  logic [1:0] fmt_sel,
  input  logic       par_en,
  input  logic [1:0] par_mode,
  input  logic       rx_ie,
  input  logic       rd_strobe,
  input  logic       attn_set,
  input  logic       attn_clr,
  output logic [7:0] rd_data,
  output logic       rd_bit9,
  output logic       rx_full,
  output logic       par_err,
  output logic       frm_err,
  output logic       brk_det,
  output logic       line_fault,
  output logic       attn,
  output logic       irq
);
  logic     line;
  logic     restart;
  logic     half_stb, half_val, vote_stb, vote;
  logic     done, nine, store;
  rx_char_t ch;

  uart_rx_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .rx_in(rx_in), .lb_in(lb_tx_in),
    .loop_en(fmt_sel == FMT_LOOP), .line(line)
  );

  uart_rx_sampler #(.OSR(OSR)) u_samp (
    .clk(clk), .rst(rst), .tick(tick), .line(line), .restart(restart),
    .half_stb(half_stb), .half_val(half_val), .vote_stb(vote_stb), .vote(vote)
  );

  uart_rx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .line(line),
    .half_stb(half_stb), .half_val(half_val), .vote_stb(vote_stb), .vote(vote),
    .fmt(fmt_e'(fmt_sel)), .par_en(par_en), .par_mode(par_e'(par_mode)),
    .restart(restart), .done(done), .nine(nine), .ch(ch), .line_fault(line_fault)
  );

  uart_rx_buf u_buf (
    .clk(clk), .rst(rst), .done(done), .nine(nine), .ch(ch),
    .rd_strobe(rd_strobe), .attn_set(attn_set), .attn_clr(attn_clr),
    .store(store), .rd_data(rd_data), .rd_bit9(rd_bit9), .full(rx_full),
    .par_err(par_err), .frm_err(frm_err), .brk(brk_det), .attn(attn)
  );

  assign irq = rx_full & rx_ie;
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
  input logic clk,
  input logic rst,
  input logic rd_strobe,
  input logic attn_clr,
  input logic store,
  input logic line,
  input logic rx_full,
  input logic attn,
  input logic line_fault
);
  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !store) |=> !rx_full);

  // R5
  store_sets_full_chk: assert property (@(posedge clk) disable iff (rst)
    store |=> rx_full);

  // R5
  full_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(store));

  // R11
  attn_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(attn) |-> $past(attn_clr || store));

  // R10
  fault_release_chk: assert property (@(posedge clk) disable iff (rst)
    (line_fault && line) |=> !line_fault);
endmodule

bind uart_rx_top uart_rx_chk u_chk (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .attn_clr(attn_clr),
  .store(store), .line(line), .rx_full(rx_full), .attn(attn),
  .line_fault(line_fault)
);

// File: tb/uart_rx_top_test.sv
module uart_rx_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rx_in = 1'b1, lb_tx_in = 1'b1;
  logic [1:0] fmt_sel = 2'b00, par_mode = 2'b00;
  logic       par_en = 1'b0, rx_ie = 1'b0, rd_strobe = 1'b0;
  logic       attn_set = 1'b0, attn_clr = 1'b0;
  logic [7:0] rd_data;
  logic       rd_bit9, rx_full, par_err, frm_err, brk_det, line_fault, attn, irq;

  int n_chk = 0, n_fail = 0;
  logic [1:0] tcnt = 2'd0;
  logic f8, f12, lf12, lf_after;
  logic [7:0] cap_data;

  uart_rx_top uut (
    .clk(clk), .rst(rst), .tick(tick), .rx_in(rx_in), .lb_tx_in(lb_tx_in),
    .fmt_sel(fmt_sel), .par_en(par_en), .par_mode(par_mode), .rx_ie(rx_ie),
    .rd_strobe(rd_strobe), .attn_set(attn_set), .attn_clr(attn_clr),
    .rd_data(rd_data), .rd_bit9(rd_bit9), .rx_full(rx_full), .par_err(par_err),
    .frm_err(frm_err), .brk_det(brk_det), .line_fault(line_fault), .attn(attn), .irq(irq)
  );

  always #2 clk = ~clk;

  // 16x tick: one cycle in four
  always @(negedge clk) begin
    tcnt <= tcnt + 2'd1;
    tick <= (tcnt == 2'd3);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_t(input int n);
    repeat (4 * n) @(negedge clk);
  endtask

  task automatic drv(input bit lb, input logic v);
    if (lb) lb_tx_in = v; else rx_in = v;
  endtask

  task automatic pulse_rd;
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  // start, nb payload bits LSB first, stop, optional glitch, extra low, idle gap
  task automatic send(input logic [9:0] pl, input int nb, input logic stopv = 1'b1,
                      input bit lb = 1'b0, input int gl = -1, input int low_x = 0,
                      input int gap = 16, input bit autord = 1'b0);
    drv(lb, 1'b0); wait_t(16);
    for (int i = 0; i < nb; i++) begin
      drv(lb, pl[i]);
      if (i == gl) begin
        wait_t(8); drv(lb, ~pl[i]); wait_t(1); drv(lb, pl[i]); wait_t(7);
      end else wait_t(16);
    end
    drv(lb, stopv);
    wait_t(8); f8 = rx_full;
    wait_t(4); f12 = rx_full; lf12 = line_fault; cap_data = rd_data;
    if (autord) pulse_rd;
    wait_t(4);
    if (low_x > 0) wait_t(low_x);
    drv(lb, 1'b1);
    wait_t(1); lf_after = line_fault;
    if (gap > 1) wait_t(gap - 1);
  endtask

  function automatic logic pgen(input logic [8:0] d, input int nd, input logic [1:0] m);
    logic x;
    x = ^(d & ((9'h1 << nd) - 9'h1));
    case (m)
      2'b00:   return ~x;
      2'b01:   return x;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary;
    $finish;
  end

  initial begin
    logic [9:0] pl;
    logic       p;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 reset state", {rx_full, par_err, frm_err, brk_det, line_fault, attn, irq, rd_bit9, rd_data}, 0);

    // R4 R5 R6: 8-bit sweep
    for (int v = 0; v < 256; v += 17) begin
      send(10'(v), 8);
      chk("R5 full low mid stop", f8, 0);
      chk("R5 full high late stop", f12, 1);
      chk("R4 8-bit data", rd_data, v);
      chk("R4 bit9 zero in 8-bit", rd_bit9, 0);
      pulse_rd;
      chk("R6 read clears full", rx_full, 0);
      chk("R6 data held after read", rd_data, v);
    end

    // R4: 7-bit format, bit 7 must read 0
    fmt_sel = 2'b01;
    for (int v = 8'h81; v < 256; v += 23) begin
      send(10'(v), 7);
      chk("R4 7-bit data", rd_data, v & 8'h7F);
      chk("R5 7-bit full", f12, 1);
      pulse_rd;
    end

    // R4: 9-bit format
    fmt_sel = 2'b10;
    for (int v = 0; v < 512; v += 73) begin
      send(10'(v), 9);
      chk("R4 9-bit low byte", rd_data, v & 8'hFF);
      chk("R4 9-bit ninth", rd_bit9, (v >> 8) & 1);
      pulse_rd;
    end

    // R8: parity, all four rules, 7 and 8 bit, good and flipped
    par_en = 1'b1;
    for (int f = 0; f < 2; f++) begin
      fmt_sel = (f == 0) ? 2'b00 : 2'b01;
      for (int m = 0; m < 4; m++) begin
        par_mode = 2'(m);
        for (int bad = 0; bad < 2; bad++) begin
          int nd;
          nd = (f == 0) ? 8 : 7;
          pl = 10'((f == 0) ? 8'h6B : 8'h3C) & ((10'h1 << nd) - 10'h1);
          p = pgen(pl[8:0], nd, 2'(m)) ^ bad[0];
          pl[nd] = p;
          send(pl, nd + 1);
          chk("R8 parity flag", par_err, bad);
          chk("R8 data with parity", rd_data, pl[7:0] & ((8'h1 << nd) - 8'h1));
          pulse_rd;
        end
      end
    end
    par_en = 1'b0;
    fmt_sel = 2'b00;

    // R3: one-tick glitch inside a bit
    send(10'h055, 8, 1'b1, 1'b0, 0);
    chk("R3 glitch on bit0", rd_data, 8'h55);
    pulse_rd;
    send(10'h0A3, 8, 1'b1, 1'b0, 5);
    chk("R3 glitch on bit5", rd_data, 8'hA3);
    pulse_rd;

    // R2: short low pulse is not a start
    rx_in = 1'b0; wait_t(4); rx_in = 1'b1; wait_t(40);
    chk("R2 short low ignored", rx_full, 0);
    send(10'h03E, 8);
    chk("R2 recovery frame", rd_data, 8'h3E);
    pulse_rd;

    // R7: back-to-back frames with a single stop bit
    send(10'h081, 8, 1'b1, 1'b0, -1, 0, 0, 1'b1);
    chk("R7 first frame", cap_data, 8'h81);
    send(10'h07E, 8);
    chk("R7 second frame not early", f8, 0);
    chk("R7 second frame stored", f12, 1);
    chk("R7 second data", rd_data, 8'h7E);
    pulse_rd;

    // R9 R10: framing error
    send(10'h0A5, 8, 1'b0);
    chk("R9 framing flag", frm_err, 1);
    chk("R9 no break on data", brk_det, 0);
    chk("R9 data kept", rd_data, 8'hA5);
    chk("R10 fault while low", lf12, 1);
    chk("R10 fault released", lf_after, 0);
    pulse_rd;
    send(10'h011, 8);
    chk("R9 flag replaced", frm_err, 0);
    pulse_rd;

    // R9 R10: long break, one character only
    send(10'h000, 8, 1'b0, 1'b0, -1, 48, 16, 1'b1);
    chk("R9 break flag", brk_det, 1);
    chk("R9 break framing", frm_err, 1);
    chk("R10 fault during break", lf12, 1);
    chk("R10 fault after break", lf_after, 0);
    chk("R10 no start during hold", rx_full, 0);
    send(10'h022, 8);
    chk("R9 break flag replaced", brk_det, 0);
    pulse_rd;

    // R11: address filter
    fmt_sel = 2'b10;
    @(negedge clk) attn_set = 1'b1;
    @(negedge clk) attn_set = 1'b0;
    chk("R11 attn set", attn, 1);
    send(10'h0AB, 9);
    chk("R11 data char dropped", f12, 0);
    chk("R11 attn kept", attn, 1);
    send(10'h1C3, 9);
    chk("R11 address stored", rx_full, 1);
    chk("R11 address data", {rd_bit9, rd_data}, 9'h1C3);
    chk("R11 attn auto clear", attn, 0);
    pulse_rd;
    send(10'h012, 9);
    chk("R11 data after address", {rx_full, rd_bit9, rd_data}, 10'h212);
    pulse_rd;
    fmt_sel = 2'b00;
    @(negedge clk) attn_set = 1'b1;
    @(negedge clk) attn_set = 1'b0;
    send(10'h066, 8);
    chk("R11 no filter in 8-bit", {rx_full, rd_data}, 9'h166);
    chk("R11 attn unchanged in 8-bit", attn, 1);
    pulse_rd;
    @(negedge clk) attn_clr = 1'b1;
    @(negedge clk) attn_clr = 1'b0;
    chk("R11 attn cleared", attn, 0);

    // R12: interrupt gating
    rx_ie = 1'b1;
    @(negedge clk);
    chk("R12 irq idle", irq, 0);
    send(10'h033, 8);
    chk("R12 irq with full", irq, 1);
    rx_ie = 1'b0;
    @(negedge clk);
    chk("R12 irq masked", irq, 0);
    rx_ie = 1'b1;
    @(negedge clk);
    chk("R12 irq unmasked", irq, 1);
    pulse_rd;
    chk("R12 irq after read", irq, 0);
    rx_ie = 1'b0;

    // R13: loopback source
    fmt_sel = 2'b11;
    wait_t(2);
    send(10'h15A, 9, 1'b1, 1'b1);
    chk("R13 loopback data", {rx_full, rd_bit9, rd_data}, 10'h35A);
    pulse_rd;
    send(10'h0F0, 9, 1'b1, 1'b0);
    chk("R13 pin ignored", f12, 0);
    chk("R13 pin ignored end", rx_full, 0);
    fmt_sel = 2'b00;

    summary;
    $finish;
  end
endmodule